// File: doc/BRIEF.md
# Function-Select Mini ALU

A purely combinational arithmetic-logic unit with two equal-width operands, `a_i` and `b_i`. A two-bit function code `func_i` comes from a control unit and picks one of four operations: unsigned addition, bitwise inversion of `a_i`, bitwise OR, or bitwise AND. The chosen value appears on `res_o`. The operand and result width is set by the `WIDTH` parameter and defaults to 2 bits.

The addition runs through a chain of one-bit full adders, and the carry passes from bit to bit. The carry leaving the top bit is reported on `ovf_o`. That flag means something only for addition and is held low for the other three codes. The block has no clock and no storage. Outputs settle from the inputs within the same cycle, so a surrounding datapath registers them where it needs to.

Top module: `mini_alu`

## Requirements
- R1: With `func_i` = 2'b00, `res_o` equals `a_i + b_i` modulo 2^WIDTH.
- R2: With `func_i` = 2'b00, `ovf_o` equals the carry out of the most significant bit of the unsigned sum of `a_i` and `b_i`.
- R3: With `func_i` = 2'b01, `res_o` equals the bitwise inverse of `a_i`, and the value of `b_i` has no effect on `res_o` or `ovf_o`.
- R4: With `func_i` = 2'b10, `res_o` equals `a_i | b_i`.
- R5: With `func_i` = 2'b11, `res_o` equals `a_i & b_i`.
- R6: For every `func_i` other than 2'b00, `ovf_o` is 0.
- R7: The outputs depend only on the present inputs. A change of inputs shows on `res_o` and `ovf_o` without any clock edge.
- R8: A carry born in bit 0 travels through every higher bit. All-ones plus one gives a zero result with `ovf_o` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| func_i | input | 2 | Function code: 00 add, 01 invert a_i, 10 OR, 11 AND |
| res_o | output | WIDTH | Result of the selected function |
| ovf_o | output | 1 | Unsigned carry out of the addition, 0 for other codes |

## Verification
The assertions are re-evaluated whenever the ports change. They check that the result matches the arithmetic or bitwise reference for each function code, that the overflow flag equals the unsigned carry during addition, and that the flag stays low otherwise. Some behaviours cannot be seen from a single input combination, so only the bench's scenarios show them. One is that `b_i` is ignored under inversion, which the bench shows by sweeping `b_i` while holding `a_i`. Another is that outputs settle with no clock edge. The third is a carry crossing the full width.

// File: rtl/mini_alu_pkg.sv
package mini_alu_pkg;

    typedef enum logic [1:0] {
        FN_ADD  = 2'b00,
        FN_INVA = 2'b01,
        FN_OR   = 2'b10,
        FN_AND  = 2'b11
    } alu_fn_e;

    localparam int FN_COUNT = 4;

endpackage

// File: rtl/alu_full_add.sv
module alu_full_add (
    input  logic x_i,
    input  logic y_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);
    logic half_d;

    always_comb begin
        half_d = x_i ^ y_i;
        sum_o  = half_d ^ cin_i;
        cout_o = (x_i & y_i) | (half_d & cin_i);
    end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    logic [WIDTH:0] carry_d;

    assign carry_d[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        alu_full_add u_fa (
            .x_i    (x_i[i]),
            .y_i    (y_i[i]),
            .cin_i  (carry_d[i]),
            .sum_o  (sum_o[i]),
            .cout_o (carry_d[i+1])
        );
    end

    assign cout_o = carry_d[WIDTH];
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux #(
    parameter int WIDTH  = 2,
    parameter int INPUTS = 4,
    localparam int SEL_W = $clog2(INPUTS)
) (
    input  logic [INPUTS-1:0][WIDTH-1:0] cand_i,
    input  logic [SEL_W-1:0]             sel_i,
    output logic [WIDTH-1:0]             pick_o
);
    always_comb begin
        pick_o = '0;
        for (int k = 0; k < INPUTS; k++) begin
            if (sel_i == SEL_W'(k)) begin
                pick_o = cand_i[k];
            end
        end
    end
endmodule

// File: rtl/mini_alu.sv
module mini_alu
    import mini_alu_pkg::*;
#(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       func_i,
    output logic [WIDTH-1:0] res_o,
    output logic             ovf_o
);
    logic [WIDTH-1:0]                  add_sum_d;
    logic                              add_cout_d;
    logic [FN_COUNT-1:0][WIDTH-1:0]    cand_d;
    logic [WIDTH-1:0]                  res_d;
    logic                              ovf_d;

    alu_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .x_i    (a_i),
        .y_i    (b_i),
        .sum_o  (add_sum_d),
        .cout_o (add_cout_d)
    );

    always_comb begin
        cand_d          = '0;
        cand_d[FN_ADD]  = add_sum_d;
        cand_d[FN_INVA] = ~a_i;
        cand_d[FN_OR]   = a_i | b_i;
        cand_d[FN_AND]  = a_i & b_i;
        ovf_d           = (alu_fn_e'(func_i) == FN_ADD) ? add_cout_d : 1'b0;
    end

    alu_result_mux #(.WIDTH(WIDTH), .INPUTS(FN_COUNT)) u_mux (
        .cand_i (cand_d),
        .sel_i  (func_i),
        .pick_o (res_d)
    );

    assign res_o = res_d;
    assign ovf_o = ovf_d;
endmodule

// File: rtl/mini_alu_chk.sv
module mini_alu_chk #(
    parameter int WIDTH = 2
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [1:0]       fn,
    input logic [WIDTH-1:0] res,
    input logic             ovf
);
    logic [WIDTH:0] ref_sum;

    always_comb begin
        ref_sum = {1'b0, a} + {1'b0, b};
        if (fn == 2'b00) begin
            AST_ADD_SUM:   assert (res == ref_sum[WIDTH-1:0]); // R1
            AST_ADD_CARRY: assert (ovf == ref_sum[WIDTH]);     // R2
        end
        if (fn == 2'b01) begin
            AST_INV_A:     assert ((res ^ a) == '1);           // R3
        end
        if (fn == 2'b10) begin
            AST_OR_RES:    assert (res == (a | b));            // R4
        end
        if (fn == 2'b11) begin
            AST_AND_RES:   assert (res == (a & b));            // R5
        end
        if (fn != 2'b00) begin
            AST_NO_OVERFLOW: assert (!ovf);                    // R6
        end
    end
endmodule

bind mini_alu mini_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a   (a_i),
    .b   (b_i),
    .fn  (func_i),
    .res (res_o),
    .ovf (ovf_o)
);

// File: tb/mini_alu_test.sv
`timescale 1ns/1ps
module mini_alu_test;
    localparam int W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b;
    logic [1:0]   fn;
    logic [W-1:0] res;
    logic         ovf;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    mini_alu #(.WIDTH(W)) uut (
        .a_i(a), .b_i(b), .func_i(fn), .res_o(res), .ovf_o(ovf)
    );

    // {a, b, fn, expected res, expected ovf}
    localparam int NV = 8;
    localparam logic [8:0] VEC [NV] = '{
        {2'b01, 2'b01, 2'b00, 2'b10, 1'b0},
        {2'b11, 2'b01, 2'b00, 2'b00, 1'b1},
        {2'b10, 2'b10, 2'b00, 2'b00, 1'b1},
        {2'b10, 2'b11, 2'b01, 2'b01, 1'b0},
        {2'b00, 2'b00, 2'b01, 2'b11, 1'b0},
        {2'b01, 2'b10, 2'b10, 2'b11, 1'b0},
        {2'b11, 2'b10, 2'b11, 2'b10, 1'b0},
        {2'b01, 2'b10, 2'b11, 2'b00, 1'b0}
    };

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb_, input logic [1:0] tf);
        @(negedge clk);
        a = ta; b = tb_; fn = tf;
        #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; fn = 2'b00;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 R2 idle state: zero operands added
        check("R1 idle", {ovf, res}, 3'b000);

        // R1 R2 R3 R4 R5 R6 table vectors
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][8:7], VEC[i][6:5], VEC[i][4:3]);
            check("R1-5 table", {ovf, res}, {VEC[i][0], VEC[i][2:1]});
        end

        // exhaustive sweep against reference expressions
        for (int f = 0; f < 4; f++) begin
            for (int ia = 0; ia < (1 << W); ia++) begin
                for (int ib = 0; ib < (1 << W); ib++) begin
                    logic [W:0] s;
                    apply(W'(ia), W'(ib), 2'(f));
                    s = {1'b0, W'(ia)} + {1'b0, W'(ib)};
                    case (f)
                        0: check("R1 R2 add", {ovf, res}, s);
                        1: check("R3 R6 inv", {ovf, res}, {1'b0, ~W'(ia)});
                        2: check("R4 R6 or", {ovf, res}, {1'b0, W'(ia) | W'(ib)});
                        default: check("R5 R6 and", {ovf, res}, {1'b0, W'(ia) & W'(ib)});
                    endcase
                end
            end
        end

        // R3: b swept with a held, output must not move
        for (int ib = 0; ib < (1 << W); ib++) begin
            apply(2'b01, W'(ib), 2'b01);
            check("R3 b ignored", {ovf, res}, 3'b010);
        end

        // R8: carry through every bit
        apply('1, W'(1), 2'b00);
        check("R8 ripple", {ovf, res}, {1'b1, {W{1'b0}}});
        apply('1, '1, 2'b00);
        check("R8 max add", {ovf, res}, {1'b1, {(W-1){1'b1}}, 1'b0});

        // R6: operands that would overflow, under non-add codes
        apply('1, '1, 2'b10);
        check("R6 or no ovf", {2'b0, ovf}, 3'b000);
        apply('1, '1, 2'b11);
        check("R6 and no ovf", {2'b0, ovf}, 3'b000);

        // R7: settles with no clock edge between change and sample
        @(posedge clk);
        #0.5;
        a = 2'b10; b = 2'b01; fn = 2'b00;
        #0.5;
        check("R7 comb add", {ovf, res}, 3'b011);
        fn = 2'b01;
        #0.5;
        check("R7 comb inv", {ovf, res}, 3'b001);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule